// File: doc/BRIEF.md
# Multi-Channel Thermal Threshold Monitor

This block watches a set of temperature-sensor ADC channels without any software help once it has been set up. A scan engine asks the ADC for one channel at a time, round-robin. It waits a programmable number of cycles between accesses. As soon as the latest reading of any channel sits on the hot side of either of its two limits, the engine switches to a second, separately programmed wait. Every reading is compared against a per-channel alarm limit and a per-channel shutdown limit. Each comparison passes through its own consecutive-sample filter.

A filtered alarm sets a sticky per-channel interrupt flag, which software clears by writing ones. A filtered shutdown latches a request on one of two routes, chosen per channel: a reset-controller line or a GPIO pin. The GPIO pin has a programmable active level. A latched shutdown is released only by a block reset.

Software programs everything through a write-only register port. The ADC is seen as a request/response port that returns a raw code.

Top module: `thermo_guard`

## Requirements
- R1: No ADC request is issued while CTRL bit 0 (run) is 0. With run set, requests visit channels 0,1,...,NCH-1 and then wrap to 0. A request is held until the ADC acknowledges it.
- R2: With the ADC answering in the request cycle, and every channel's latest reading cool, consecutive request starts are PER_NORM+2 cycles apart. PER_NORM is at address 0x01.
- R3: While the latest reading of any channel exceeds its alarm or shutdown limit, consecutive request starts are PER_FAST+2 cycles apart. PER_FAST is at address 0x02.
- R4: CTRL bit 2 sets the comparison sense. When it is 1, a value exceeds a limit if it is greater than the limit. When it is 0, a value exceeds a limit if it is less than the limit.
- R5: When CTRL bit 1 is set, the compared value is (1024 - code) modulo 2^CODE_W. Otherwise the compared value is the raw code.
- R6: The DEBOUNCE register (0x03) holds the alarm count in bits [7:0] and the shutdown count in bits [15:8]. An event fires only on the Nth consecutive exceeding sample of its channel. Any non-exceeding sample restarts that count, and a count of 0 acts as 1.
- R7: A channel's status bit can only be set while its bit in INT_EN (0x04) is 1. The irq output is the OR of all status bits.
- R8: Writing STATUS (0x05) clears every status bit whose data bit is 1. If a set and a clear hit the same bit in the same cycle, the set wins.
- R9: A ROUTE write (0x06) selects a channel with data bits [7:0]. Bit 8 enables shutdown for that channel, and bit 9 picks the target: 0 for the reset line, 1 for the GPIO pin. Selecting one target drops the other, and bit 8 = 0 drops both. A filtered shutdown of a channel latches on its selected target only.
- R10: CTRL bit 3 gives the GPIO active level: 1 means active high and 0 means active low. The pin shows the inactive level when nothing is latched, including right after reset.
- R11: A latched shutdown stays asserted, even after readings cool, until the block reset, which clears it.
- R12: Alarm limits (0x10+ch) and shutdown limits (0x20+ch) keep only the low CODE_W bits of the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| adc_req | output | 1 | ADC conversion request, held until acknowledged |
| adc_chan | output | CH_W | Channel being requested |
| adc_ack | input | 1 | ADC response valid |
| adc_code | input | CODE_W | Raw ADC code, valid with adc_ack |
| irq | output | 1 | OR of the interrupt status bits |
| irq_status | output | NCH | Sticky per-channel alarm flags |
| shut_reset | output | 1 | Latched shutdown toward the reset controller, active high |
| shut_gpio | output | 1 | Latched shutdown pin with programmable level |

## Verification
Two functions can act on the same status bit in one cycle: a filtered alarm setting it from a fresh sample, and a software write-one-to-clear. The bench provokes this collision by watching for the request of channel 0 while that channel reads hot. It then issues a clear of all bits so that the write lands in exactly the cycle when the sample's result is applied. The bench expects channel 0 to stay set, because the set wins. It also expects a second channel that was flagged earlier, and is not being sampled, to be cleared by that same write.

// File: rtl/thermo_guard_pkg.sv
package thermo_guard_pkg;

    localparam int ADDR_W = 6;
    localparam int REG_W  = 16;
    localparam int Q_BASE = 1024;

    localparam logic [ADDR_W-1:0] A_CTRL     = 6'h00;
    localparam logic [ADDR_W-1:0] A_PER_NORM = 6'h01;
    localparam logic [ADDR_W-1:0] A_PER_FAST = 6'h02;
    localparam logic [ADDR_W-1:0] A_DEBOUNCE = 6'h03;
    localparam logic [ADDR_W-1:0] A_INT_EN   = 6'h04;
    localparam logic [ADDR_W-1:0] A_STATUS   = 6'h05;
    localparam logic [ADDR_W-1:0] A_ROUTE    = 6'h06;
    localparam int                A_ALARM    = 16;
    localparam int                A_SHUT     = 32;

    typedef struct packed {
        logic gpio_high;
        logic hot_gt;
        logic invert;
        logic run;
    } ctrl_t;

    typedef enum logic {SQ_WAIT, SQ_REQ} seq_state_e;

    function automatic logic hot_side(input logic [31:0] v, input logic [31:0] t, input logic gt);
        return gt ? (v > t) : (v < t);
    endfunction

endpackage

// File: rtl/tg_regs.sv
module tg_regs
    import thermo_guard_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CODE_W = 10,
    parameter int PER_W  = 16,
    parameter int DEB_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [REG_W-1:0]             wdata,
    output ctrl_t                        ctrl,
    output logic [PER_W-1:0]             per_norm,
    output logic [PER_W-1:0]             per_fast,
    output logic [DEB_W-1:0]             int_deb,
    output logic [DEB_W-1:0]             shut_deb,
    output logic [NCH-1:0]               int_en,
    output logic [NCH-1:0][CODE_W-1:0]   alarm_thr,
    output logic [NCH-1:0][CODE_W-1:0]   shut_thr,
    output logic [NCH-1:0]               route_rst,
    output logic [NCH-1:0]               route_gpio,
    output logic [NCH-1:0]               clr_vec
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            per_norm <= '0;
            per_fast <= '0;
            int_deb  <= '0;
            shut_deb <= '0;
            int_en   <= '0;
        end else if (we) begin
            case (addr)
                A_CTRL:     ctrl     <= ctrl_t'(wdata[3:0]);
                A_PER_NORM: per_norm <= wdata[PER_W-1:0];
                A_PER_FAST: per_fast <= wdata[PER_W-1:0];
                A_DEBOUNCE: begin
                    int_deb  <= wdata[DEB_W-1:0];
                    shut_deb <= wdata[8 +: DEB_W];
                end
                A_INT_EN:   int_en   <= wdata[NCH-1:0];
                default: ;
            endcase
        end
    end

    always_comb clr_vec = (we && addr == A_STATUS) ? wdata[NCH-1:0] : '0;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                alarm_thr[g] <= '0;
                shut_thr[g]  <= '0;
            end else if (we) begin
                if (addr == ADDR_W'(A_ALARM + g)) alarm_thr[g] <= wdata[CODE_W-1:0];
                if (addr == ADDR_W'(A_SHUT + g))  shut_thr[g]  <= wdata[CODE_W-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                route_rst[g]  <= 1'b0;
                route_gpio[g] <= 1'b0;
            end else if (we && addr == A_ROUTE && wdata[7:0] == 8'(g)) begin
                route_rst[g]  <= wdata[8] && !wdata[9];
                route_gpio[g] <= wdata[8] &&  wdata[9];
            end
        end

        p_route_excl_r9: assert property (@(posedge clk) disable iff (rst)
            !(route_rst[g] && route_gpio[g]))
            else $error("route both targets");
    end

endmodule

// File: rtl/tg_sequencer.sv
module tg_sequencer
    import thermo_guard_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CODE_W = 10,
    parameter int PER_W  = 16,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              fast_sel,
    input  logic [PER_W-1:0]  per_norm,
    input  logic [PER_W-1:0]  per_fast,
    output logic              adc_req,
    output logic [CH_W-1:0]   adc_chan,
    input  logic              adc_ack,
    input  logic [CODE_W-1:0] adc_code,
    output logic              smp_valid,
    output logic [CH_W-1:0]   smp_chan,
    output logic [CODE_W-1:0] smp_code
);

    seq_state_e       state;
    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] cur_per;

    always_comb cur_per = fast_sel ? per_fast : per_norm;
    always_comb adc_req = (state == SQ_REQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_WAIT;
            cnt       <= '0;
            adc_chan  <= '0;
            smp_valid <= 1'b0;
            smp_chan  <= '0;
            smp_code  <= '0;
        end else begin
            smp_valid <= 1'b0;
            case (state)
                SQ_WAIT: begin
                    if (!run) begin
                        cnt <= '0;
                    end else if (cnt >= cur_per) begin
                        cnt   <= '0;
                        state <= SQ_REQ;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_REQ: begin
                    if (adc_ack) begin
                        smp_valid <= 1'b1;
                        smp_chan  <= adc_chan;
                        smp_code  <= adc_code;
                        adc_chan  <= (adc_chan == CH_W'(NCH - 1)) ? '0 : adc_chan + 1'b1;
                        state     <= SQ_WAIT;
                    end
                end
                default: state <= SQ_WAIT;
            endcase
        end
    end

    p_req_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (adc_req && !adc_ack) |=> adc_req)
        else $error("request dropped before ack");

    p_smp_src_r2: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> $past(adc_req && adc_ack))
        else $error("sample without handshake");

endmodule

// File: rtl/tg_debounce.sv
module tg_debounce #(
    parameter int DEB_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             hot,
    input  logic [DEB_W-1:0] goal,
    output logic             reached
);

    localparam logic [DEB_W-1:0] CNT_MAX = '1;

    logic [DEB_W-1:0] cnt;
    logic [DEB_W:0]   nxt;
    logic [DEB_W:0]   eff_goal;

    always_comb begin
        nxt      = (DEB_W+1)'(cnt) + (DEB_W+1)'(1);
        eff_goal = (goal == '0) ? (DEB_W+1)'(1) : (DEB_W+1)'(goal);
        reached  = step && hot && (nxt >= eff_goal);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= !hot ? '0 : ((cnt == CNT_MAX) ? cnt : cnt + 1'b1);
    end

    p_cnt_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (step && !hot) |=> (cnt == '0))
        else $error("count not restarted");

endmodule

// File: rtl/tg_channel.sv
module tg_channel
    import thermo_guard_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int DEB_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_here,
    input  logic [CODE_W-1:0] smp_code,
    input  ctrl_t             ctrl,
    input  logic [CODE_W-1:0] alarm_thr,
    input  logic [CODE_W-1:0] shut_thr,
    input  logic [DEB_W-1:0]  int_deb,
    input  logic [DEB_W-1:0]  shut_deb,
    input  logic              int_en,
    input  logic              clr,
    input  logic              route_rst,
    input  logic              route_gpio,
    output logic              status,
    output logic              hot_flag,
    output logic              shut_rst,
    output logic              shut_gpio
);

    logic [CODE_W-1:0] value;
    logic              a_hot, s_hot;
    logic              int_fire, shut_fire;

    always_comb begin
        value = ctrl.invert ? CODE_W'(Q_BASE - 32'(smp_code)) : smp_code;
        a_hot = hot_side(32'(value), 32'(alarm_thr), ctrl.hot_gt);
        s_hot = hot_side(32'(value), 32'(shut_thr),  ctrl.hot_gt);
    end

    tg_debounce #(.DEB_W(DEB_W)) u_int_deb (
        .clk(clk), .rst(rst), .step(smp_here), .hot(a_hot),
        .goal(int_deb), .reached(int_fire)
    );

    tg_debounce #(.DEB_W(DEB_W)) u_shut_deb (
        .clk(clk), .rst(rst), .step(smp_here), .hot(s_hot),
        .goal(shut_deb), .reached(shut_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status    <= 1'b0;
            hot_flag  <= 1'b0;
            shut_rst  <= 1'b0;
            shut_gpio <= 1'b0;
        end else begin
            status    <= (status && !clr) || (int_fire && int_en);
            shut_rst  <= shut_rst  || (shut_fire && route_rst);
            shut_gpio <= shut_gpio || (shut_fire && route_gpio);
            if (smp_here) hot_flag <= a_hot || s_hot;
        end
    end

    p_status_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (!status && !int_en) |=> !status)
        else $error("status set while disabled");

    p_shut_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (shut_rst || shut_gpio) |=> (shut_rst || shut_gpio))
        else $error("shutdown released");

endmodule

// File: rtl/thermo_guard.sv
module thermo_guard
    import thermo_guard_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CODE_W = 10,
    parameter int PER_W  = 16,
    parameter int DEB_W  = 8,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              adc_req,
    output logic [CH_W-1:0]   adc_chan,
    input  logic              adc_ack,
    input  logic [CODE_W-1:0] adc_code,
    output logic              irq,
    output logic [NCH-1:0]    irq_status,
    output logic              shut_reset,
    output logic              shut_gpio
);

    ctrl_t                       ctrl;
    logic [PER_W-1:0]            per_norm, per_fast;
    logic [DEB_W-1:0]            int_deb, shut_deb;
    logic [NCH-1:0]              int_en, route_rst, route_gpio, clr_vec;
    logic [NCH-1:0][CODE_W-1:0]  alarm_thr, shut_thr;
    logic                        smp_valid;
    logic [CH_W-1:0]             smp_chan;
    logic [CODE_W-1:0]           smp_code;
    logic [NCH-1:0]              hot_flag, lat_rst, lat_gpio;

    tg_regs #(.NCH(NCH), .CODE_W(CODE_W), .PER_W(PER_W), .DEB_W(DEB_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .ctrl(ctrl), .per_norm(per_norm), .per_fast(per_fast),
        .int_deb(int_deb), .shut_deb(shut_deb), .int_en(int_en),
        .alarm_thr(alarm_thr), .shut_thr(shut_thr),
        .route_rst(route_rst), .route_gpio(route_gpio), .clr_vec(clr_vec)
    );

    tg_sequencer #(.NCH(NCH), .CODE_W(CODE_W), .PER_W(PER_W)) u_seq (
        .clk(clk), .rst(rst), .run(ctrl.run), .fast_sel(|hot_flag),
        .per_norm(per_norm), .per_fast(per_fast),
        .adc_req(adc_req), .adc_chan(adc_chan), .adc_ack(adc_ack), .adc_code(adc_code),
        .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_code(smp_code)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        tg_channel #(.CODE_W(CODE_W), .DEB_W(DEB_W)) u_ch (
            .clk(clk), .rst(rst),
            .smp_here(smp_valid && smp_chan == CH_W'(g)),
            .smp_code(smp_code), .ctrl(ctrl),
            .alarm_thr(alarm_thr[g]), .shut_thr(shut_thr[g]),
            .int_deb(int_deb), .shut_deb(shut_deb),
            .int_en(int_en[g]), .clr(clr_vec[g]),
            .route_rst(route_rst[g]), .route_gpio(route_gpio[g]),
            .status(irq_status[g]), .hot_flag(hot_flag[g]),
            .shut_rst(lat_rst[g]), .shut_gpio(lat_gpio[g])
        );
    end

    always_comb begin
        irq        = |irq_status;
        shut_reset = |lat_rst;
        shut_gpio  = ctrl.gpio_high ? (|lat_gpio) : !(|lat_gpio);
    end

endmodule

// File: tb/sim_thermo_guard.sv
module sim_thermo_guard;
    import thermo_guard_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int CODE_W = 10;
    localparam logic [15:0] C_RUN = 16'h1, C_INV = 16'h2, C_GT = 16'h4, C_GPH = 16'h8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic adc_req, adc_ack;
    logic [1:0] adc_chan;
    logic [CODE_W-1:0] adc_code;
    logic irq, shut_reset, shut_gpio;
    logic [NCH-1:0] irq_status;

    int checks = 0, errors = 0, cyc = 0, req_rises = 0;
    int samp_cnt [NCH];
    logic [CODE_W-1:0] codes [NCH];
    int chan_hist [8];
    logic prev_req = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermo_guard u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .adc_req(adc_req), .adc_chan(adc_chan), .adc_ack(adc_ack), .adc_code(adc_code),
        .irq(irq), .irq_status(irq_status), .shut_reset(shut_reset), .shut_gpio(shut_gpio)
    );

    initial forever begin @(posedge clk); cyc++; end

    // ADC model: answers in the request cycle
    initial begin
        adc_ack = 1'b0; adc_code = '0;
        for (int i = 0; i < NCH; i++) begin samp_cnt[i] = 0; codes[i] = 10'd100; end
        forever begin
            @(negedge clk);
            if (adc_req && !adc_ack) begin
                adc_ack = 1'b1; adc_code = codes[adc_chan]; samp_cnt[adc_chan]++;
            end else adc_ack = 1'b0;
        end
    end

    initial forever begin
        @(negedge clk);
        if (adc_req && !prev_req) begin req_rises++; chan_hist[req_rises % 8] = int'(adc_chan); end
        prev_req = adc_req;
    end

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog: actual hung, expected completion");
        summary();
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic set_code(input int ch, input int v);
        @(posedge clk); codes[ch] = CODE_W'(v);
    endtask

    task automatic wait_samp(input int ch, input int n);
        int tgt = samp_cnt[ch] + n;
        while (samp_cnt[ch] < tgt) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic measure_gap(output int gap);
        int t0;
        do @(negedge clk); while (adc_req);
        do @(negedge clk); while (!adc_req);
        t0 = cyc;
        do @(negedge clk); while (adc_req);
        do @(negedge clk); while (!adc_req);
        gap = cyc - t0;
    endtask

    task automatic all_limits(input int al, input int sh);
        for (int i = 0; i < NCH; i++) begin
            wr(6'(A_ALARM + i), 16'(al));
            wr(6'(A_SHUT + i), 16'(sh));
        end
    endtask

    task automatic t_reset();
        chk("R10 reset gpio idle", int'(shut_gpio), 1);
        chk("R11 reset shut_reset", int'(shut_reset), 0);
        chk("R7 reset irq", int'(irq), 0);
        chk("R8 reset status", int'(irq_status), 0);
        chk("R1 reset no request", int'(adc_req), 0);
    endtask

    task automatic t_scan_order();
        int s;
        wr(A_PER_NORM, 16'd2); wr(A_PER_FAST, 16'd2);
        all_limits(500, 800);
        repeat (40) @(negedge clk);
        chk("R1 idle while run=0", req_rises, 0);
        s = req_rises;
        wr(A_CTRL, C_RUN | C_GT);
        while (req_rises < s + 5) @(negedge clk);
        for (int k = 1; k <= 5; k++) chk("R1 channel order", chan_hist[(s + k) % 8], (k - 1) % NCH);
    endtask

    task automatic t_intervals();
        int gap;
        wr(A_PER_NORM, 16'd5); wr(A_PER_FAST, 16'd1);
        wait_samp(0, 1);
        measure_gap(gap); chk("R2 normal interval", gap, 7);
        set_code(0, 600); wait_samp(0, 2);
        measure_gap(gap); chk("R3 fast interval", gap, 3);
        set_code(0, 100); wait_samp(0, 2);
        measure_gap(gap); chk("R2 back to normal", gap, 7);
        wr(A_PER_NORM, 16'd2); wr(A_PER_FAST, 16'd2);
    endtask

    task automatic t_debounce();
        wr(A_DEBOUNCE, 16'h0003); wr(A_INT_EN, 16'h1); wr(A_STATUS, 16'hF);
        set_code(0, 100); wait_samp(0, 1);
        set_code(0, 600); wait_samp(0, 2);
        chk("R6 two hot samples", int'(irq_status), 0);
        wait_samp(0, 1);
        chk("R6 third hot sample", int'(irq_status), 1);
        chk("R7 irq follows status", int'(irq), 1);
        set_code(0, 100); wait_samp(0, 1); wr(A_STATUS, 16'hF);
        set_code(0, 600); wait_samp(0, 2);
        set_code(0, 100); wait_samp(0, 1);
        set_code(0, 600); wait_samp(0, 2);
        chk("R6 cool sample restarts", int'(irq_status), 0);
        wait_samp(0, 1);
        chk("R6 fires after restart", int'(irq_status), 1);
        wr(A_DEBOUNCE, 16'h0000);
        set_code(0, 100); wait_samp(0, 1); wr(A_STATUS, 16'hF);
        set_code(0, 600); wait_samp(0, 1);
        chk("R6 zero count acts as one", int'(irq_status), 1);
        set_code(0, 100); wait_samp(0, 1); wr(A_STATUS, 16'hF);
    endtask

    task automatic t_enable_and_clear();
        wr(A_DEBOUNCE, 16'h0001); wr(A_INT_EN, 16'h1);
        set_code(1, 600); wait_samp(1, 3);
        chk("R7 disabled channel stays clear", int'(irq_status), 0);
        chk("R7 irq low", int'(irq), 0);
        wr(A_INT_EN, 16'h3); wait_samp(1, 1);
        chk("R7 enabled channel sets", int'(irq_status), 2);
        set_code(0, 600); wait_samp(0, 1);
        chk("R8 both set", int'(irq_status), 3);
        set_code(1, 100); wait_samp(1, 1);
        wr(A_STATUS, 16'h2);
        chk("R8 selective clear", int'(irq_status), 1);
        set_code(1, 600); wait_samp(1, 1);
        set_code(1, 100);
        chk("R8 ch1 re-set", int'(irq_status), 3);
        // collision: clear-all lands on the cycle channel 0's hot sample is applied
        do @(negedge clk); while (!(adc_req && adc_chan == 2'd0));
        @(negedge clk); reg_we = 1'b1; reg_addr = A_STATUS; reg_wdata = 16'hF;
        @(negedge clk); reg_we = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 set wins over clear", int'(irq_status), 1);
    endtask

    task automatic t_direction_invert();
        wr(A_INT_EN, 16'h0);
        wr(A_CTRL, C_RUN);
        set_code(0, 600); set_code(1, 600); set_code(3, 600); set_code(2, 100);
        wait_samp(3, 2); wr(A_STATUS, 16'hF);
        wr(A_INT_EN, 16'hC); wait_samp(2, 1); wait_samp(3, 1);
        chk("R4 less-than sense", int'(irq_status), 4);
        wr(A_INT_EN, 16'h0);
        wr(A_CTRL, C_RUN | C_GT | C_INV);
        set_code(3, 100); set_code(2, 1000);
        wait_samp(3, 2); wr(A_STATUS, 16'hF);
        wr(A_INT_EN, 16'hC); wait_samp(2, 1); wait_samp(3, 1);
        chk("R5 inverted value", int'(irq_status), 8);
        wr(A_INT_EN, 16'h0);
        wr(A_CTRL, C_RUN | C_GT);
        for (int i = 0; i < NCH; i++) set_code(i, 100);
        wr(6'(A_ALARM), 16'h0405);
        wait_samp(3, 2); wr(A_STATUS, 16'hF);
        wr(A_INT_EN, 16'h1); wait_samp(0, 1);
        chk("R12 limit masked", int'(irq_status), 1);
        wr(A_INT_EN, 16'h0); wr(A_STATUS, 16'hF);
    endtask

    task automatic t_shutdown();
        wr(A_CTRL, C_RUN | C_GT | C_GPH);
        @(negedge clk);
        chk("R10 active-high idle", int'(shut_gpio), 0);
        wr(A_DEBOUNCE, 16'h0201);
        wr(A_ROUTE, 16'h0101);
        wr(A_ROUTE, 16'h0301);
        set_code(1, 900); wait_samp(1, 1);
        chk("R9 shut debounce pending", int'(shut_gpio), 0);
        wait_samp(1, 1);
        chk("R9 gpio route fires", int'(shut_gpio), 1);
        chk("R9 reset route cleared", int'(shut_reset), 0);
        set_code(1, 100); wait_samp(1, 2);
        chk("R11 latched after cooling", int'(shut_gpio), 1);
        @(negedge clk); rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
        chk("R11 reset releases gpio", int'(shut_gpio), 1);
        chk("R11 reset line low", int'(shut_reset), 0);
        wr(A_PER_NORM, 16'd2); wr(A_PER_FAST, 16'd2);
        all_limits(500, 800);
        wr(A_CTRL, C_RUN | C_GT);
        wr(A_ROUTE, 16'h0302);
        wr(A_ROUTE, 16'h0102);
        set_code(2, 900); wait_samp(2, 1);
        chk("R9 reset route fires", int'(shut_reset), 1);
        chk("R9 gpio route cleared", int'(shut_gpio), 1);
        wr(A_ROUTE, 16'h0303);
        set_code(3, 900); wait_samp(3, 1);
        chk("R10 active-low asserted", int'(shut_gpio), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_scan_order();
        t_intervals();
        t_debounce();
        t_enable_and_clear();
        t_direction_invert();
        t_shutdown();
        summary();
    end

endmodule